// File: doc/BRIEF.md
# Vector Register-Group Layout Shuffler

This block converts between a packed little-endian memory image and the registers of a vector register group. The placement of every element depends only on the element width and the group multiplier, never on a lane-striping setting, so software can predict the layout from those two values alone. Register width is 128 bits (16 bytes). Element width may be 8, 16 or 32 bits, and the group multiplier may be 1/4, 1/2, 1, 2 or 4.

The load path accepts a packed buffer of up to 64 bytes together with a configuration. It then issues one register of the group per beat, in register order, with a per-byte write enable. The store path accepts a configuration, then takes register beats in the same order and rebuilds the packed image. The two paths are independent and can be active in the same clock cycle. With a whole multiplier G, element i sits in register i mod G at byte offset (i div G)·bytes-per-element. With a fraction 1/F, every element lies in register 0 at byte offset i·F·bytes-per-element, and the other bytes of each slot are left untouched.

Top module: `vlay_shuffler`

## Requirements
- R1: Width code 0/1/2 selects 8/16/32-bit elements. With multiplier code 0 (multiplier 1), a load gives one beat with index 0 and last set. Register byte b equals memory byte b for all 16 bytes, and every enable bit is 1.
- R2: Multiplier code 1 (2) and code 2 (4) give G beats with indices 0..G-1, and last is set only on beat G-1. Element i lands in register i mod G at byte offset (i div G)·bytes-per-element, and every enable bit is 1.
- R3: Multiplier code 7 (1/2) and code 6 (1/4) give one beat. Element i lands at byte offset i·F·bytes-per-element. The enable bit is 1 only for the low bytes-per-element bytes of each F·bytes-per-element slot and 0 for the gap bytes.
- R4: Byte k of an element is placed at register byte n+k, where n is the element's starting offset, in the little-endian order of memory.
- R5: A width code of 3 or a multiplier code of 3, 4 or 5 is unsupported.
- R6: An unsupported request is still accepted. It raises the matching error output for exactly one cycle, starting the cycle after acceptance. It produces no load beat, and on the store side it opens no beat window and gives no done.
- R7: While a load beat is offered and not taken, its index, data and enables stay unchanged. The load request ready is low whenever a beat is being offered.
- R8: The store path takes G beats (one beat for fractional multipliers) and drops gap bytes. Done pulses for one cycle, starting the cycle after the last beat is taken. The image then holds the transferred bytes (16·multiplier of them) in memory order, holds zeros above them, and stays unchanged until the next accepted request.
- R9: A load and a store can be in progress in the same cycle without either affecting the other's results.
- R10: After reset both request readies are high, no load beat is offered, the store takes no beats, and done and both error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req_valid | input | 1 | Load request offered |
| ld_req_ready | output | 1 | Load path idle and able to take a request |
| ld_sew | input | 2 | Load element width code |
| ld_lmul | input | 3 | Load group multiplier code |
| ld_mem | input | 512 | Packed memory image, byte 0 in bits 7:0 |
| ld_beat_valid | output | 1 | Register beat offered |
| ld_beat_ready | input | 1 | Consumer takes the beat |
| ld_beat_data | output | 128 | Register contents for this beat |
| ld_beat_be | output | 16 | Per-byte write enable |
| ld_beat_idx | output | 2 | Register index within the group |
| ld_beat_last | output | 1 | Final beat of the group |
| ld_err | output | 1 | Unsupported load configuration pulse |
| st_req_valid | input | 1 | Store request offered |
| st_req_ready | output | 1 | Store path idle and able to take a request |
| st_sew | input | 2 | Store element width code |
| st_lmul | input | 3 | Store group multiplier code |
| st_beat_valid | input | 1 | Register beat supplied |
| st_beat_ready | output | 1 | Store path is collecting beats |
| st_beat_data | input | 128 | Register contents for this beat |
| st_done | output | 1 | Packed image complete pulse |
| st_image | output | 512 | Rebuilt packed memory image |
| st_err | output | 1 | Unsupported store configuration pulse |

## Verification
The load path can offer a beat in the same cycle that the store path takes one, or raises done, because they share only the clock and reset. The bench runs a multi-beat load and a multi-beat store in parallel branches with different width and multiplier codes and random back-pressure. Both results are judged against the bench's own forward placement of elements. Any cross-talk would show up as a wrong byte in a load beat or in the rebuilt image.

// File: rtl/vlay_pkg.sv
package vlay_pkg;

  localparam int REG_BYTES  = 16;
  localparam int MAX_GRP_LG = 2;
  localparam int MAX_GRP    = 1 << MAX_GRP_LG;
  localparam int MEM_BYTES  = REG_BYTES * MAX_GRP;
  localparam int MIDX_W     = $clog2(MEM_BYTES);
  localparam int GRP_W      = MAX_GRP_LG;

  typedef struct packed {
    logic       ok;
    logic [1:0] sew_lg;   // log2 of bytes per element
    logic [1:0] grp_lg;   // log2 of whole multiplier
    logic [1:0] frac_lg;  // log2 of fractional divisor
  } lay_cfg_t;

  typedef struct packed {
    logic              en;
    logic [MIDX_W-1:0] src;
  } byte_src_t;

  // Turn the raw codes into a layout descriptor.
  function automatic lay_cfg_t decode_cfg(logic [1:0] sew_code, logic [2:0] lmul_code);
    lay_cfg_t c;
    c        = '0;
    c.sew_lg = sew_code;
    case (lmul_code)
      3'd0:    c.ok = 1'b1;
      3'd1:    begin c.ok = 1'b1; c.grp_lg  = 2'd1; end
      3'd2:    begin c.ok = 1'b1; c.grp_lg  = 2'd2; end
      3'd7:    begin c.ok = 1'b1; c.frac_lg = 2'd1; end
      3'd6:    begin c.ok = 1'b1; c.frac_lg = 2'd2; end
      default: c.ok = 1'b0;
    endcase
    if (sew_code == 2'd3) c.ok = 1'b0;
    return c;
  endfunction

  // For register r, byte b: which packed memory byte it carries, and whether it is used.
  function automatic byte_src_t reg_byte_src(lay_cfg_t c, int unsigned r, int unsigned b);
    byte_src_t   s;
    int unsigned esz;
    int unsigned slot;
    int unsigned off;
    int unsigned span_lg;
    int unsigned idx;
    esz = 32'd1 << c.sew_lg;
    if (c.frac_lg == 2'd0) begin
      slot = b >> c.sew_lg;
      off  = b & (esz - 32'd1);
      idx  = (((slot << c.grp_lg) + r) * esz) + off;
      s.en = 1'b1;
    end else begin
      span_lg = 32'(c.sew_lg) + 32'(c.frac_lg);
      slot    = b >> span_lg;
      off     = b & ((32'd1 << span_lg) - 32'd1);
      idx     = (slot * esz) + off;
      s.en    = (off < esz);
    end
    s.src = MIDX_W'(idx);
    return s;
  endfunction

  function automatic logic [GRP_W-1:0] last_beat(lay_cfg_t c);
    return GRP_W'((32'd1 << c.grp_lg) - 32'd1);
  endfunction

endpackage

// File: rtl/vlay_cfg_dec.sv
module vlay_cfg_dec
  import vlay_pkg::*;
(
  input  logic [1:0] sew_code,
  input  logic [2:0] lmul_code,
  output lay_cfg_t   cfg
);
  assign cfg = decode_cfg(sew_code, lmul_code);
endmodule

// File: rtl/vlay_ld_path.sv
module vlay_ld_path
  import vlay_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  lay_cfg_t                       cfg_in,
  input  logic [MEM_BYTES-1:0][7:0]      mem_in,
  output logic                           beat_valid,
  input  logic                           beat_ready,
  output logic [REG_BYTES-1:0][7:0]      beat_data,
  output logic [REG_BYTES-1:0]           beat_be,
  output logic [GRP_W-1:0]               beat_idx,
  output logic                           beat_last,
  output logic                           err,
  output logic                           req_fire,
  output logic                           beat_fire
);
  typedef enum logic {LD_IDLE, LD_SEND} ld_state_e;

  ld_state_e                  state_q;
  lay_cfg_t                   cfg_q;
  logic [MEM_BYTES-1:0][7:0]  mem_q;
  logic [GRP_W-1:0]           beat_q;
  logic                       err_q;

  assign req_ready  = (state_q == LD_IDLE);
  assign req_fire   = req_valid && req_ready;
  assign beat_valid = (state_q == LD_SEND);
  assign beat_fire  = beat_valid && beat_ready;
  assign beat_idx   = beat_q;
  assign beat_last  = (beat_q == last_beat(cfg_q));
  assign err        = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      cfg_q   <= '0;
      mem_q   <= '0;
      beat_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= req_fire && !cfg_in.ok;
      case (state_q)
        LD_IDLE: if (req_fire && cfg_in.ok) begin
          state_q <= LD_SEND;
          cfg_q   <= cfg_in;
          mem_q   <= mem_in;
          beat_q  <= '0;
        end
        LD_SEND: if (beat_fire) begin
          if (beat_last) state_q <= LD_IDLE;
          else           beat_q  <= beat_q + 1'b1;
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  for (genvar gb = 0; gb < REG_BYTES; gb++) begin : g_gather
    byte_src_t src;
    assign src           = reg_byte_src(cfg_q, 32'(beat_q), unsigned'(gb));
    assign beat_data[gb] = mem_q[src.src];
    assign beat_be[gb]   = src.en;
  end
endmodule

// File: rtl/vlay_st_path.sv
module vlay_st_path
  import vlay_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  lay_cfg_t                       cfg_in,
  input  logic                           beat_valid,
  output logic                           beat_ready,
  input  logic [REG_BYTES-1:0][7:0]      beat_data,
  output logic                           done,
  output logic [MEM_BYTES-1:0][7:0]      image,
  output logic                           err,
  output logic                           req_fire,
  output logic                           beat_fire
);
  typedef enum logic {ST_IDLE, ST_TAKE} st_state_e;

  st_state_e                  state_q;
  lay_cfg_t                   cfg_q;
  logic [MEM_BYTES-1:0][7:0]  img_q;
  logic [GRP_W-1:0]           beat_q;
  logic                       done_q;
  logic                       err_q;
  logic                       is_last;
  byte_src_t                  dst [REG_BYTES];

  assign req_ready  = (state_q == ST_IDLE);
  assign req_fire   = req_valid && req_ready;
  assign beat_ready = (state_q == ST_TAKE);
  assign beat_fire  = beat_valid && beat_ready;
  assign is_last    = (beat_q == last_beat(cfg_q));
  assign done       = done_q;
  assign err        = err_q;
  assign image      = img_q;

  for (genvar gb = 0; gb < REG_BYTES; gb++) begin : g_scatter_map
    assign dst[gb] = reg_byte_src(cfg_q, 32'(beat_q), unsigned'(gb));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      img_q   <= '0;
      beat_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q  <= req_fire && !cfg_in.ok;
      done_q <= beat_fire && is_last;
      case (state_q)
        ST_IDLE: if (req_fire && cfg_in.ok) begin
          state_q <= ST_TAKE;
          cfg_q   <= cfg_in;
          img_q   <= '0;
          beat_q  <= '0;
        end
        ST_TAKE: if (beat_fire) begin
          for (int b = 0; b < REG_BYTES; b++) begin
            if (dst[b].en) img_q[dst[b].src] <= beat_data[b];
          end
          if (is_last) state_q <= ST_IDLE;
          else         beat_q  <= beat_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vlay_shuffler.sv
module vlay_shuffler
  import vlay_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld_req_valid,
  output logic                        ld_req_ready,
  input  logic [1:0]                  ld_sew,
  input  logic [2:0]                  ld_lmul,
  input  logic [MEM_BYTES*8-1:0]      ld_mem,
  output logic                        ld_beat_valid,
  input  logic                        ld_beat_ready,
  output logic [REG_BYTES*8-1:0]      ld_beat_data,
  output logic [REG_BYTES-1:0]        ld_beat_be,
  output logic [GRP_W-1:0]            ld_beat_idx,
  output logic                        ld_beat_last,
  output logic                        ld_err,
  input  logic                        st_req_valid,
  output logic                        st_req_ready,
  input  logic [1:0]                  st_sew,
  input  logic [2:0]                  st_lmul,
  input  logic                        st_beat_valid,
  output logic                        st_beat_ready,
  input  logic [REG_BYTES*8-1:0]      st_beat_data,
  output logic                        st_done,
  output logic [MEM_BYTES*8-1:0]      st_image,
  output logic                        st_err
);
  lay_cfg_t ld_cfg;
  lay_cfg_t st_cfg;
  logic     ld_req_fire;
  logic     ld_beat_fire;
  logic     st_req_fire;
  logic     st_beat_fire;

  vlay_cfg_dec u_ld_dec (.sew_code(ld_sew), .lmul_code(ld_lmul), .cfg(ld_cfg));
  vlay_cfg_dec u_st_dec (.sew_code(st_sew), .lmul_code(st_lmul), .cfg(st_cfg));

  vlay_ld_path u_ld (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (ld_req_valid),
    .req_ready  (ld_req_ready),
    .cfg_in     (ld_cfg),
    .mem_in     (ld_mem),
    .beat_valid (ld_beat_valid),
    .beat_ready (ld_beat_ready),
    .beat_data  (ld_beat_data),
    .beat_be    (ld_beat_be),
    .beat_idx   (ld_beat_idx),
    .beat_last  (ld_beat_last),
    .err        (ld_err),
    .req_fire   (ld_req_fire),
    .beat_fire  (ld_beat_fire)
  );

  vlay_st_path u_st (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (st_req_valid),
    .req_ready  (st_req_ready),
    .cfg_in     (st_cfg),
    .beat_valid (st_beat_valid),
    .beat_ready (st_beat_ready),
    .beat_data  (st_beat_data),
    .done       (st_done),
    .image      (st_image),
    .err        (st_err),
    .req_fire   (st_req_fire),
    .beat_fire  (st_beat_fire)
  );
endmodule

// File: rtl/vlay_shuffler_chk.sv
module vlay_shuffler_chk
  import vlay_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ld_req_ready,
  input logic                   ld_req_fire,
  input logic                   ld_beat_valid,
  input logic                   ld_beat_ready,
  input logic                   ld_beat_fire,
  input logic [GRP_W-1:0]       ld_beat_idx,
  input logic                   ld_beat_last,
  input logic [REG_BYTES*8-1:0] ld_beat_data,
  input logic [REG_BYTES-1:0]   ld_beat_be,
  input logic                   ld_err,
  input logic                   st_req_ready,
  input logic                   st_req_fire,
  input logic                   st_beat_ready,
  input logic                   st_beat_fire,
  input logic                   st_done,
  input logic                   st_err,
  input logic [MEM_BYTES*8-1:0] st_image
);
  // R7
  ld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_beat_valid && !ld_beat_ready |=> ld_beat_valid && $stable(ld_beat_idx)
      && $stable(ld_beat_data) && $stable(ld_beat_be));

  // R7
  ld_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_req_ready && ld_beat_valid));

  // R2
  ld_first_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req_fire |=> !ld_beat_valid || ld_beat_idx == '0);

  // R2
  ld_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_beat_fire && !ld_beat_last |=> ld_beat_valid && ld_beat_idx == GRP_W'($past(ld_beat_idx) + 1'b1));

  // R6
  ld_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_err |-> !ld_beat_valid && ld_req_ready);

  // R6
  st_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_err |-> st_req_ready && !st_beat_ready && !st_done);

  // R8
  st_done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |-> $past(st_beat_fire) && st_req_ready);

  // R8
  st_hold_img_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_req_fire && !st_beat_fire |=> $stable(st_image));

  // R8
  st_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |=> !st_done);
endmodule

bind vlay_shuffler vlay_shuffler_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ld_req_ready  (ld_req_ready),
  .ld_req_fire   (ld_req_fire),
  .ld_beat_valid (ld_beat_valid),
  .ld_beat_ready (ld_beat_ready),
  .ld_beat_fire  (ld_beat_fire),
  .ld_beat_idx   (ld_beat_idx),
  .ld_beat_last  (ld_beat_last),
  .ld_beat_data  (ld_beat_data),
  .ld_beat_be    (ld_beat_be),
  .ld_err        (ld_err),
  .st_req_ready  (st_req_ready),
  .st_req_fire   (st_req_fire),
  .st_beat_ready (st_beat_ready),
  .st_beat_fire  (st_beat_fire),
  .st_done       (st_done),
  .st_err        (st_err),
  .st_image      (st_image)
);

// File: tb/sim_vlay_shuffler.sv
`timescale 1ns/1ps
module sim_vlay_shuffler;
  import vlay_pkg::*;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_req_valid = 1'b0;
  logic         ld_req_ready;
  logic [1:0]   ld_sew = '0;
  logic [2:0]   ld_lmul = '0;
  logic [511:0] ld_mem = '0;
  logic         ld_beat_valid;
  logic         ld_beat_ready = 1'b0;
  logic [127:0] ld_beat_data;
  logic [15:0]  ld_beat_be;
  logic [1:0]   ld_beat_idx;
  logic         ld_beat_last;
  logic         ld_err;
  logic         st_req_valid = 1'b0;
  logic         st_req_ready;
  logic [1:0]   st_sew = '0;
  logic [2:0]   st_lmul = '0;
  logic         st_beat_valid = 1'b0;
  logic         st_beat_ready;
  logic [127:0] st_beat_data = '0;
  logic         st_done;
  logic [511:0] st_image;
  logic         st_err;

  int  total = 0;
  int  bad = 0;
  bit  ld_expect = 1'b0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  vlay_shuffler u0 (.*);

  task automatic chk(bit ok, string req, string what, logic [511:0] act, logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bench decoding of codes, written from the requirement text.
  function automatic void codes(input logic [1:0] s, input logic [2:0] l,
                                output int esz, output int g, output int f);
    esz = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    g = 1; f = 1;
    if (l == 3'd1) g = 2;
    if (l == 3'd2) g = 4;
    if (l == 3'd7) f = 2;
    if (l == 3'd6) f = 4;
  endfunction

  // Forward placement: walk the elements and drop each into its register slot.
  function automatic void place(input int esz, input int g, input int f,
                                input logic [7:0] m [64],
                                output logic [7:0] r [4][16], output bit e [4][16]);
    int ne;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 16; b++) begin r[a][b] = 8'h00; e[a][b] = 1'b0; end
    ne = (16 * g) / (esz * f);
    for (int i = 0; i < ne; i++) begin
      int j, n;
      if (g > 1)      begin j = i % g; n = (i / g) * esz; end
      else if (f > 1) begin j = 0;     n = i * f * esz;   end
      else            begin j = 0;     n = i * esz;       end
      for (int k = 0; k < esz; k++) begin
        r[j][n + k] = m[i * esz + k];
        e[j][n + k] = 1'b1;
      end
    end
  endfunction

  task automatic run_load(logic [1:0] s, logic [2:0] l, string req, bit stall);
    logic [7:0] m [64];
    logic [7:0] r [4][16];
    bit         e [4][16];
    int esz, g, f;
    codes(s, l, esz, g, f);
    for (int i = 0; i < 64; i++) m[i] = 8'($urandom);
    place(esz, g, f, m, r, e);
    @(negedge clk);
    for (int i = 0; i < 64; i++) ld_mem[i*8 +: 8] = m[i];
    ld_sew = s; ld_lmul = l; ld_req_valid = 1'b1;
    while (!ld_req_ready) @(negedge clk);
    ld_expect = 1'b1;
    @(negedge clk);
    ld_req_valid = 1'b0;
    for (int b = 0; b < g; b++) begin
      logic [127:0] ed, mk;
      logic [15:0]  eb;
      if (stall) begin
        ld_beat_ready = 1'b0;
        repeat (1 + $urandom % 2) @(negedge clk);
        chk(ld_beat_valid && ld_beat_idx == 2'(b), "R7", "held beat idx", 512'(ld_beat_idx), 512'(b));
      end
      ld_beat_ready = 1'b1;
      for (int k = 0; k < 16; k++) begin
        eb[k] = e[b][k];
        ed[k*8 +: 8] = e[b][k] ? r[b][k] : 8'h00;
        mk[k*8 +: 8] = e[b][k] ? 8'hff : 8'h00;
      end
      chk(ld_beat_valid && ld_beat_idx == 2'(b), req, "beat idx", 512'(ld_beat_idx), 512'(b));
      chk(ld_beat_last == (b == g - 1), req, "last flag", 512'(ld_beat_last), 512'(b == g - 1));
      chk(ld_beat_be == eb, req, "byte enable", 512'(ld_beat_be), 512'(eb));
      chk((ld_beat_data & mk) == ed, req, "beat data (R4 byte order)", 512'(ld_beat_data & mk), 512'(ed));
      @(negedge clk);
      ld_beat_ready = 1'b0;
    end
    ld_expect = 1'b0;
    chk(!ld_beat_valid && ld_req_ready, "R7", "load returns idle", 512'(ld_beat_valid), 512'(0));
  endtask

  task automatic run_store(logic [1:0] s, logic [2:0] l, string req, bit stall);
    logic [7:0]   m [64];
    logic [7:0]   r [4][16];
    bit           e [4][16];
    logic [511:0] exp_img;
    int esz, g, f, nb;
    codes(s, l, esz, g, f);
    for (int i = 0; i < 64; i++) m[i] = 8'($urandom);
    place(esz, g, f, m, r, e);
    nb = (16 * g) / f;
    for (int i = 0; i < 64; i++) exp_img[i*8 +: 8] = (i < nb) ? m[i] : 8'h00;
    @(negedge clk);
    st_sew = s; st_lmul = l; st_req_valid = 1'b1;
    while (!st_req_ready) @(negedge clk);
    @(negedge clk);
    st_req_valid = 1'b0;
    for (int b = 0; b < g; b++) begin
      if (stall) begin
        st_beat_valid = 1'b0;
        repeat (1 + $urandom % 2) @(negedge clk);
      end
      for (int k = 0; k < 16; k++) st_beat_data[k*8 +: 8] = e[b][k] ? r[b][k] : 8'($urandom);
      st_beat_valid = 1'b1;
      while (!st_beat_ready) @(negedge clk);
      @(negedge clk);
      st_beat_valid = 1'b0;
      if (b < g - 1) chk(!st_done, "R8", "no early done", 512'(st_done), 512'(0));
    end
    chk(st_done, "R8", "done after last beat", 512'(st_done), 512'(1));
    chk(st_image == exp_img, req, "rebuilt image", st_image, exp_img);
    @(negedge clk);
    chk(!st_done && st_image == exp_img, "R8", "done pulse ends, image held", st_image, exp_img);
  endtask

  task automatic bad_load(logic [1:0] s, logic [2:0] l);
    @(negedge clk);
    ld_sew = s; ld_lmul = l; ld_req_valid = 1'b1;
    while (!ld_req_ready) @(negedge clk);
    @(negedge clk);
    ld_req_valid = 1'b0;
    chk(ld_err && !ld_beat_valid, "R6", "load error pulse", 512'({ld_err, ld_beat_valid}), 512'(2'b10));
    @(negedge clk);
    chk(!ld_err && !ld_beat_valid && ld_req_ready, "R5", "unsupported load code ignored",
        512'({ld_err, ld_beat_valid, ld_req_ready}), 512'(3'b001));
  endtask

  task automatic bad_store(logic [1:0] s, logic [2:0] l);
    logic [511:0] prev;
    @(negedge clk);
    prev = st_image;
    st_sew = s; st_lmul = l; st_req_valid = 1'b1;
    while (!st_req_ready) @(negedge clk);
    @(negedge clk);
    st_req_valid = 1'b0;
    chk(st_err && !st_beat_ready && !st_done, "R6", "store error pulse",
        512'({st_err, st_beat_ready, st_done}), 512'(3'b100));
    @(negedge clk);
    chk(!st_err && st_req_ready && st_image == prev, "R6", "store error leaves image", st_image, prev);
  endtask

  // Every-clock monitor: no load beat when the bench model expects none.
  always @(negedge clk) begin
    if (rst_n && !ld_expect && ld_beat_valid) begin
      total++; bad++;
      $display("FAIL R7 spurious load beat actual=1 expected=0");
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ld_req_ready && st_req_ready && !ld_beat_valid && !st_beat_ready && !st_done && !ld_err && !st_err,
        "R10", "state in reset", 512'({ld_req_ready, st_req_ready, ld_beat_valid, st_done}), 512'(4'b1100));
    rst_n = 1'b1;
    @(negedge clk);
    chk(ld_req_ready && st_req_ready && !ld_beat_valid && !st_done, "R10", "state after reset",
        512'({ld_req_ready, st_req_ready}), 512'(2'b11));

    for (int s = 0; s < 3; s++) run_load(2'(s), 3'd0, "R1", 1'b0);
    for (int s = 0; s < 3; s++) begin
      run_load(2'(s), 3'd1, "R2", 1'b1);
      run_load(2'(s), 3'd2, "R2", 1'b0);
      run_load(2'(s), 3'd7, "R3", 1'b0);
      run_load(2'(s), 3'd6, "R3", 1'b1);
    end
    for (int s = 0; s < 3; s++) begin
      run_store(2'(s), 3'd0, "R1", 1'b0);
      run_store(2'(s), 3'd1, "R2", 1'b1);
      run_store(2'(s), 3'd2, "R2", 1'b0);
      run_store(2'(s), 3'd7, "R3", 1'b1);
      run_store(2'(s), 3'd6, "R8", 1'b0);
    end

    bad_load(2'd3, 3'd0);
    bad_load(2'd0, 3'd3);
    bad_load(2'd1, 3'd5);
    bad_store(2'd2, 3'd4);
    bad_store(2'd3, 3'd1);

    // R9: both paths busy in the same cycles
    fork
      run_load(2'd2, 3'd2, "R9", 1'b1);
      run_store(2'd0, 3'd2, "R9", 1'b1);
    join
    fork
      run_load(2'd0, 3'd6, "R9", 1'b0);
      run_store(2'd1, 3'd1, "R9", 1'b0);
    join

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule